// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block picks the way to overwrite when a lookup misses in a set-associative cache. It sits beside the tag array. Each cycle it receives three things for the addressed set: its index, the valid bits of its ways, and the outcome of the lookup (a hit on a given way, or a miss). It returns the way number that a fill should use. The result is combinational, so the way is known in the same cycle as the miss.

Three replacement disciplines are available, chosen by a select input. The block keeps the state for all three up to date at all times, so the select may change at any cycle. The three states are:
- a single free-running counter shared by every set, for pseudo-random choice;
- a per-set round-robin pointer that moves only on misses, for first-in-first-out order;
- a per-set recency ordering that moves on hits and on fills, for least-recently-used choice.

An empty way always takes priority over the policy choice. Tag storage, data storage and the rest of the cache datapath belong to the surrounding design.

Top module: `way_victim_sel`

## Requirements
- R1: When any way of the addressed set has its valid bit low, victim_way is the lowest-numbered such way, whatever the policy.
- R2: The shared random counter is 0 after reset and advances by one on every clock edge, wrapping from WAYS-1 to 0. With pol_sel = 0 and all ways valid, victim_way equals the counter in the same cycle.
- R3: With pol_sel = 1 and all ways valid, victim_way equals the round-robin pointer of the addressed set. Every pointer is 0 after reset.
- R4: A set's round-robin pointer advances by one, wrapping at WAYS-1, on each miss in that set. Hits, idle cycles and misses in other sets leave it unchanged.
- R5: With pol_sel = 2 or 3 and all ways valid, victim_way is the least recently used way of the addressed set.
- R6: A hit (hit high, miss low) makes hit_way the most recently used way of its set.
- R7: A miss makes the way reported on victim_way in that cycle the most recently used way of its set. This applies when the way was chosen because it was empty as well as when the policy chose it.
- R8: Reset orders every set with way 0 least recent, then way 1, and so on, with way WAYS-1 most recent.
- R9: When hit and miss are both high, the cycle is handled as a miss, and hit_way has no effect on the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_sel | input | 2 | Policy: 0 random, 1 FIFO, 2 or 3 LRU |
| set_idx | input | $clog2(SETS) | Set addressed this cycle |
| hit | input | 1 | Lookup hit in the addressed set |
| hit_way | input | $clog2(WAYS) | Way that hit |
| miss | input | 1 | Lookup missed; the fill goes to victim_way |
| way_valid | input | WAYS | Valid bits of the addressed set, bit i for way i |
| victim_way | output | $clog2(WAYS) | Way chosen for replacement |

## Verification
The bench targets these corner cases:
- Round-robin wrap after the last way. A design that stops or jumps there repeats or skips a way.
- Hits and misses to neighbouring sets. A pointer that moves on these shifts every later FIFO victim.
- The recency update after a fill into an empty way. A design that updates only on hits makes that way the next LRU victim again.
- A cycle with hit and miss both high, where letting the hit win reorders the set wrongly.
- A second reset after heavy traffic, which must restore way 0 as least recent and zero every pointer. A design that leaves stale state fails these checks.

// File: rtl/vsel_pkg.sv
`timescale 1ns/1ps
package vsel_pkg;

  typedef enum logic [1:0] {
    POL_RND  = 2'd0,
    POL_FIFO = 2'd1,
    POL_LRU  = 2'd2
  } policy_e;

  // Modulo increment used by the random counter and the round-robin pointers.
  function automatic int unsigned next_mod(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Age of one way after a way of age touched_age is touched.
  // The touched way becomes age 0 (newest); younger ways grow one older.
  function automatic int unsigned age_after_touch(input int unsigned age,
                                                  input int unsigned touched_age,
                                                  input bit          is_touched);
    if (is_touched)           return 0;
    if (age < touched_age)    return age + 1;
    return age;
  endfunction

endpackage

// File: rtl/vs_rand_ctr.sv
`timescale 1ns/1ps
module vs_rand_ctr #(
  parameter int WAYS = 4,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [WW-1:0] cnt
);
  import vsel_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= WW'(next_mod(int'(cnt), WAYS));
  end
endmodule

// File: rtl/vs_fifo_ptrs.sv
`timescale 1ns/1ps
module vs_fifo_ptrs #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [SW-1:0] set_idx,
  output logic [WW-1:0] ptr
);
  import vsel_pkg::*;

  logic [WW-1:0] ptr_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[set_idx] <= WW'(next_mod(int'(ptr_q[set_idx]), WAYS));
    end
  end

  assign ptr = ptr_q[set_idx];
endmodule

// File: rtl/vs_lru_order.sv
`timescale 1ns/1ps
module vs_lru_order #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [WW-1:0] touch_way,
  input  logic [SW-1:0] set_idx,
  output logic [WW-1:0] lru_way
);
  import vsel_pkg::*;

  if (WAYS == 2) begin : g_bit
    // Two ways: one bit per set naming the older way.
    logic [SETS-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        older_q <= '0;
      else if (touch_en) older_q[set_idx] <= ~touch_way[0];
    end

    assign lru_way = WW'(older_q[set_idx]);
  end else begin : g_age
    // Wider sets: an age per way, 0 newest, WAYS-1 oldest.
    logic [WW-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            age_q[s][w] <= WW'(WAYS - 1 - w);
      end else if (touch_en) begin
        for (int w = 0; w < WAYS; w++)
          age_q[set_idx][w] <= WW'(age_after_touch(int'(age_q[set_idx][w]),
                                                   int'(age_q[set_idx][touch_way]),
                                                   w == int'(touch_way)));
      end
    end

    always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_idx][w] == WW'(WAYS - 1)) lru_way = WW'(w);
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
`timescale 1ns/1ps
module way_victim_sel #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pol_sel,
  input  logic [SW-1:0]   set_idx,
  input  logic            hit,
  input  logic [WW-1:0]   hit_way,
  input  logic            miss,
  input  logic [WAYS-1:0] way_valid,
  output logic [WW-1:0]   victim_way
);
  import vsel_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [WW-1:0] rnd_cnt;
  logic [WW-1:0] fifo_ptr_sel;
  logic [WW-1:0] lru_way_sel;
  logic          have_free;
  logic [WW-1:0] free_way;
  logic [WW-1:0] pol_way;
  logic          touch_en;
  logic [WW-1:0] touch_way;

  vs_rand_ctr #(.WAYS(WAYS)) u_rnd (
    .clk (clk),
    .rst_n (rst_n),
    .cnt (rnd_cnt)
  );

  vs_fifo_ptrs #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (miss),
    .set_idx (set_idx),
    .ptr     (fifo_ptr_sel)
  );

  vs_lru_order #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .set_idx   (set_idx),
    .lru_way   (lru_way_sel)
  );

  // Lowest-numbered empty way.
  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        have_free = 1'b1;
        free_way  = WW'(w);
      end
    end
  end

  always_comb begin
    case (pol_sel)
      POL_RND:  pol_way = rnd_cnt;
      POL_FIFO: pol_way = fifo_ptr_sel;
      default:  pol_way = lru_way_sel;
    endcase
  end

  assign victim_way = have_free ? free_way : pol_way;

  // A miss wins over a simultaneous hit: the fill way is touched.
  assign touch_en  = miss | hit;
  assign touch_way = miss ? victim_way : hit_way;
endmodule

// File: rtl/vs_checker.sv
`timescale 1ns/1ps
module vs_checker #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SW-1:0]   set_idx,
  input logic            hit,
  input logic [WW-1:0]   hit_way,
  input logic            miss,
  input logic [WAYS-1:0] way_valid,
  input logic [WW-1:0]   victim_way,
  input logic [WW-1:0]   rnd_cnt,
  input logic [WW-1:0]   fifo_ptr_sel,
  input logic [WW-1:0]   lru_way_sel
);

  assert_free_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(&way_valid) |-> !way_valid[victim_way]);

  assert_rand_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rnd_cnt == ((int'($past(rnd_cnt)) == WAYS - 1) ? '0 : $past(rnd_cnt) + 1'b1));

  assert_fifo_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (set_idx != $past(set_idx)) ||
             fifo_ptr_sel == ((int'($past(fifo_ptr_sel)) == WAYS - 1) ? '0 : $past(fifo_ptr_sel) + 1'b1));

  assert_fifo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |=> (set_idx != $past(set_idx)) || fifo_ptr_sel == $past(fifo_ptr_sel));

  assert_hit_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !miss) |=> (set_idx != $past(set_idx)) || lru_way_sel != $past(hit_way));

  assert_fill_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (set_idx != $past(set_idx)) || lru_way_sel != $past(victim_way));

endmodule

bind way_victim_sel vs_checker #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_idx      (set_idx),
  .hit          (hit),
  .hit_way      (hit_way),
  .miss         (miss),
  .way_valid    (way_valid),
  .victim_way   (victim_way),
  .rnd_cnt      (rnd_cnt),
  .fifo_ptr_sel (fifo_ptr_sel),
  .lru_way_sel  (lru_way_sel)
);

// File: tb/sim_way_victim_sel.sv
`timescale 1ns/1ps
module sim_way_victim_sel;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW   = $clog2(WAYS);
  localparam int SW   = $clog2(SETS);
  localparam int NV   = 21;

  // Vector fields: pol(2) set(4) hit(1) hit_way(2) miss(1) valid(4)
  localparam logic [13:0] VEC [NV] = '{
    {2'd2, 4'd3,  1'b0, 2'd0, 1'b1, 4'hF},   // R5 LRU miss, way 0 oldest
    {2'd2, 4'd3,  1'b0, 2'd0, 1'b1, 4'hF},   // R7 filled way now newest
    {2'd2, 4'd3,  1'b1, 2'd2, 1'b0, 4'hF},   // R6 hit refreshes way 2
    {2'd2, 4'd3,  1'b0, 2'd0, 1'b1, 4'hF},   // R5
    {2'd3, 4'd3,  1'b0, 2'd0, 1'b1, 4'hF},   // R5 code 3 is LRU
    {2'd1, 4'd5,  1'b0, 2'd0, 1'b1, 4'hF},   // R3 FIFO
    {2'd1, 4'd5,  1'b1, 2'd0, 1'b0, 4'hF},   // R4 hit leaves pointer
    {2'd1, 4'd6,  1'b0, 2'd0, 1'b1, 4'hF},   // R4 other set
    {2'd1, 4'd5,  1'b0, 2'd0, 1'b1, 4'hF},   // R4
    {2'd1, 4'd5,  1'b0, 2'd0, 1'b1, 4'hF},   // R4
    {2'd1, 4'd5,  1'b0, 2'd0, 1'b1, 4'hF},   // R4 last way
    {2'd1, 4'd5,  1'b0, 2'd0, 1'b1, 4'hF},   // R4 wrap to 0
    {2'd1, 4'd7,  1'b0, 2'd0, 1'b1, 4'b1011}, // R1
    {2'd2, 4'd7,  1'b0, 2'd0, 1'b1, 4'b0110}, // R1
    {2'd0, 4'd7,  1'b0, 2'd0, 1'b1, 4'b0111}, // R1
    {2'd2, 4'd7,  1'b0, 2'd0, 1'b1, 4'hF},   // R7 empty-way fills reorder
    {2'd0, 4'd8,  1'b0, 2'd0, 1'b1, 4'hF},   // R2
    {2'd0, 4'd8,  1'b0, 2'd0, 1'b0, 4'hF},   // R2
    {2'd0, 4'd9,  1'b0, 2'd0, 1'b1, 4'hF},   // R2
    {2'd2, 4'd10, 1'b1, 2'd3, 1'b1, 4'hF},   // R9 hit and miss together
    {2'd2, 4'd10, 1'b0, 2'd0, 1'b0, 4'hF}    // R9 effect visible
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      pol_sel = '0;
  logic [SW-1:0]   set_idx = '0;
  logic            hit = 1'b0;
  logic [WW-1:0]   hit_way = '0;
  logic            miss = 1'b0;
  logic [WAYS-1:0] way_valid = '1;
  logic [WW-1:0]   victim_way;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements.
  int rnd_m;
  int fifo_m [SETS];
  int ord_m  [SETS][WAYS];   // index 0 = least recent

  always #4 clk = ~clk;

  way_victim_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk (clk), .rst_n (rst_n), .pol_sel (pol_sel), .set_idx (set_idx),
    .hit (hit), .hit_way (hit_way), .miss (miss), .way_valid (way_valid),
    .victim_way (victim_way)
  );

  always @(posedge clk) begin
    if (!rst_n) rnd_m <= 0;
    else        rnd_m <= (rnd_m + 1) % WAYS;
  end

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      fifo_m[s] = 0;
      for (int k = 0; k < WAYS; k++) ord_m[s][k] = k;
    end
  endtask

  task automatic model_touch(input int s, input int w);
    int pos = 0;
    for (int k = 0; k < WAYS; k++) if (ord_m[s][k] == w) pos = k;
    for (int k = pos; k < WAYS - 1; k++) ord_m[s][k] = ord_m[s][k + 1];
    ord_m[s][WAYS - 1] = w;
  endtask

  function automatic int expect_victim(input int pol, input int s, input logic [WAYS-1:0] v);
    for (int w = 0; w < WAYS; w++) if (!v[w]) return w;
    if (pol == 0) return rnd_m;
    if (pol == 1) return fifo_m[s];
    return ord_m[s][0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: victim_way actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [13:0] v);
    int e;
    @(negedge clk);
    pol_sel   = v[13:12];
    set_idx   = v[11:8];
    hit       = v[7];
    hit_way   = v[6:5];
    miss      = v[4];
    way_valid = v[3:0];
    #1;
    e = expect_victim(int'(pol_sel), int'(set_idx), way_valid);
    check(tag, int'(victim_way), e);
    if (miss) begin
      fifo_m[set_idx] = (fifo_m[set_idx] + 1) % WAYS;
      model_touch(int'(set_idx), e);
    end else if (hit) begin
      model_touch(int'(set_idx), int'(hit_way));
    end
  endtask

  task automatic idle_peek(input string tag, input int pol, input int s);
    step(tag, {pol[1:0], s[3:0], 1'b0, 2'd0, 1'b0, 4'hF});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hit = 1'b0; miss = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    model_reset();
    do_reset();
    // Reset state: R8, R3, R2
    idle_peek("R8 reset LRU set 0",  2, 0);
    idle_peek("R8 reset LRU set 15", 2, 15);
    idle_peek("R3 reset FIFO set 4", 1, 4);
    idle_peek("R2 counter after reset", 0, 2);
    idle_peek("R2 counter next cycle", 0, 2);

    for (int i = 0; i < NV; i++) step($sformatf("vector %0d (R1..R9 per table)", i), VEC[i]);

    // Second reset after traffic: R8 and R3/R4 state cleared
    do_reset();
    idle_peek("R8 LRU set 3 after reset",  2, 3);
    idle_peek("R8 LRU set 10 after reset", 2, 10);
    idle_peek("R8 LRU set 7 after reset",  2, 7);
    idle_peek("R3 FIFO set 5 after reset", 1, 5);
    idle_peek("R2 counter after reset", 0, 5);

    // Hit on the oldest way then miss: R6 then R5
    step("R6 hit oldest way", {2'd2, 4'd12, 1'b1, 2'd0, 1'b0, 4'hF});
    step("R5 next oldest",    {2'd2, 4'd12, 1'b0, 2'd0, 1'b1, 4'hF});
    idle_peek("R7 after fill", 2, 12);

    @(negedge clk);
    hit = 1'b0; miss = 1'b0;
    finish_up();
  end
endmodule